// File: doc/BRIEF.md
# Asynchronous Per-Byte Output Handshake Engine (SCSI initiator side)

This block moves a counted block of bytes from the initiator onto a parallel SCSI bus in asynchronous mode. Each byte gets its own full four-step REQ/ACK exchange. A single REQ assertion or a single ready indication never releases a burst. The host pulses `start_i` with a byte count and the bus phase it expects. It then feeds bytes through a valid/ready stream. The engine waits for the target to raise REQ. It checks the phase lines, drops ATN if it is still raised, drives the byte, lets it settle, and raises ACK. It then waits for REQ to fall, releases ACK and the data bus, and counts the byte as sent.

All bus inputs are taken as active-high logic levels. Pad inversion lies outside the block. REQ, BSY, SEL and the phase lines share one two-flop synchronizer. Every wait for a REQ edge is bounded by a timeout. Every such wait also ends when the bus goes free. The transfer ends with a one-cycle done pulse, an error cause and the number of bytes not sent.

Top module: `async_tx_initiator`

## Requirements
- R1: At most one stream byte is accepted per REQ/ACK cycle. After a byte is taken, no further byte is accepted until ACK has been asserted and released again.
- R2: After start, the engine waits for the synchronized REQ before accepting a byte. Until then `in_ready_o` and `bus_data_en_o` stay low.
- R3: When REQ is seen and the phase lines (bit 2 = MSG, bit 1 = C/D, bit 0 = I/O) differ from `exp_phase_i`, the transfer ends without taking a byte. The error code is 1 and `left_o` holds the bytes still unsent.
- R4: `atn_raise_i` sets ATN only while idle. If ATN is set when REQ arrives with a matching phase, ATN is released before the byte is driven.
- R5: The byte is driven on `bus_data_o` with `bus_data_en_o` high for at least SETTLE_CYC full clock cycles before ACK rises. The byte stays unchanged while ACK is high. The byte is the one taken from the stream.
- R6: With ACK high, the engine waits for REQ to fall. It then releases ACK and the data bus, and `left_o` drops by one.
- R7: A transfer whose bytes all complete ends with done, error code 0 and `left_o` = 0.
- R8: If either REQ wait lasts TO_CYC cycles, the transfer ends with error code 2. ACK is released and `left_o` counts the byte in flight as unsent.
- R9: If BSY and SEL are both low (after synchronization) during either REQ wait, the transfer ends with error code 3.
- R10: `done_o` is high for exactly one cycle per transfer. `start_i` is ignored while a transfer is running.
- R11: A start with a count of zero ends at once with done, error code 0 and `left_o` = 0. No byte is taken.
- R12: After reset, ACK, ATN, data enable, ready and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| count_i | input | CNT_W | Number of bytes to send |
| exp_phase_i | input | 3 | Expected phase {MSG, C/D, I/O} |
| atn_raise_i | input | 1 | Raise ATN (honoured when idle) |
| in_data_i | input | 8 | Stream byte |
| in_valid_i | input | 1 | Stream byte valid |
| in_ready_o | output | 1 | Stream byte accepted when valid |
| bus_req_i | input | 1 | Target REQ level |
| bus_bsy_i | input | 1 | BSY level |
| bus_sel_i | input | 1 | SEL level |
| bus_phase_i | input | 3 | Phase lines {MSG, C/D, I/O} |
| bus_data_o | output | 8 | Data bus value |
| bus_data_en_o | output | 1 | Data bus drive enable |
| bus_ack_o | output | 1 | ACK level |
| bus_atn_o | output | 1 | ATN level |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 2 | 0 none, 1 phase, 2 timeout, 3 bus free |
| left_o | output | CNT_W | Bytes not sent |

## Verification
The hardest case to reach is a fault that arrives after the byte is already on the bus with ACK high. Here the bytes left must still count the byte in flight, and ACK must drop without a REQ release. The bench reaches this state with a target model that raises REQ and answers ACK, but never releases REQ, which forces the second-wait timeout. A separate scenario takes the bus free between two bytes, once one byte has completed. The phase-mismatch case flips the phase lines at the same edge REQ rises, so both cross the synchronizer together.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_PHASE   = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_BUSFREE = 2'd3
  } atx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_REQ  = 3'd1,
    ST_LOAD      = 3'd2,
    ST_SETTLE    = 3'd3,
    ST_WAIT_NREQ = 3'd4,
    ST_DONE      = 3'd5
  } atx_state_e;

endpackage

// File: rtl/atx_sync.sv
module atx_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end

    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/atx_timer.sv
module atx_timer #(
  parameter int TO_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int TMR_W = $clog2(TO_CYC + 1);
  localparam logic [TMR_W-1:0] LIMIT = TMR_W'(TO_CYC);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == LIMIT);
  assign cnt_en    = clr_i | (run_i & ~expired_o);

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/atx_ctrl.sv
module atx_ctrl
  import atx_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       exp_phase_i,
  input  logic             atn_raise_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             req_s_i,
  input  logic             bus_free_s_i,
  input  logic [2:0]       phase_s_i,
  input  logic             tmo_i,
  output logic             tmr_clr_o,
  output logic             tmr_run_o,
  output logic [7:0]       data_o,
  output logic             data_en_o,
  output logic             ack_o,
  output logic             atn_o,
  output logic             done_o,
  output atx_err_e         err_o,
  output logic [CNT_W-1:0] left_o
);

  localparam int SET_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  atx_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [7:0]       data_q, data_d;
  logic             den_q, den_d;
  logic             ack_q, ack_d;
  logic             atn_q, atn_d;
  atx_err_e         err_q, err_d;
  logic [SET_W-1:0] scnt_q, scnt_d;
  logic             take;

  assign take = (state_q == ST_LOAD) & in_valid_i;

  // next-state process
  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    data_d    = data_q;
    den_d     = den_q;
    ack_d     = ack_q;
    atn_d     = atn_q;
    err_d     = err_q;
    scnt_d    = scnt_q;
    tmr_clr_o = 1'b0;
    tmr_run_o = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (atn_raise_i) begin
          atn_d = 1'b1;
        end
        if (start_i) begin
          left_d = count_i;
          err_d  = ERR_NONE;
          if (count_i == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d   = ST_WAIT_REQ;
            tmr_clr_o = 1'b1;
          end
        end
      end

      ST_WAIT_REQ: begin
        tmr_run_o = 1'b1;
        if (bus_free_s_i) begin
          err_d   = ERR_BUSFREE;
          state_d = ST_DONE;
        end else if (tmo_i) begin
          err_d   = ERR_TIMEOUT;
          state_d = ST_DONE;
        end else if (req_s_i) begin
          if (phase_s_i != exp_phase_i) begin
            err_d   = ERR_PHASE;
            state_d = ST_DONE;
          end else begin
            atn_d   = 1'b0;
            state_d = ST_LOAD;
          end
        end
      end

      ST_LOAD: begin
        if (take) begin
          data_d  = in_data_i;
          den_d   = 1'b1;
          scnt_d  = '0;
          state_d = ST_SETTLE;
        end
      end

      ST_SETTLE: begin
        if (scnt_q == SET_LAST) begin
          ack_d     = 1'b1;
          tmr_clr_o = 1'b1;
          state_d   = ST_WAIT_NREQ;
        end else begin
          scnt_d = scnt_q + 1'b1;
        end
      end

      ST_WAIT_NREQ: begin
        tmr_run_o = 1'b1;
        if (bus_free_s_i) begin
          ack_d   = 1'b0;
          den_d   = 1'b0;
          err_d   = ERR_BUSFREE;
          state_d = ST_DONE;
        end else if (tmo_i) begin
          ack_d   = 1'b0;
          den_d   = 1'b0;
          err_d   = ERR_TIMEOUT;
          state_d = ST_DONE;
        end else if (!req_s_i) begin
          ack_d  = 1'b0;
          den_d  = 1'b0;
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_d = ST_DONE;
          end else begin
            state_d   = ST_WAIT_REQ;
            tmr_clr_o = 1'b1;
          end
        end
      end

      ST_DONE: begin
        state_d = ST_IDLE;
      end

      default: begin
        state_d = ST_IDLE;
        ack_d   = 1'b0;
        den_d   = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      data_q  <= '0;
      den_q   <= 1'b0;
      ack_q   <= 1'b0;
      atn_q   <= 1'b0;
      err_q   <= ERR_NONE;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      data_q  <= data_d;
      den_q   <= den_d;
      ack_q   <= ack_d;
      atn_q   <= atn_d;
      err_q   <= err_d;
      scnt_q  <= scnt_d;
    end
  end

  assign in_ready_o = (state_q == ST_LOAD);
  assign data_o     = data_q;
  assign data_en_o  = den_q;
  assign ack_o      = ack_q;
  assign atn_o      = atn_q;
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign left_o     = left_q;

endmodule

// File: rtl/async_tx_initiator.sv
module async_tx_initiator
  import atx_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 3,
  parameter int TO_CYC     = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       exp_phase_i,
  input  logic             atn_raise_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             bus_req_i,
  input  logic             bus_bsy_i,
  input  logic             bus_sel_i,
  input  logic [2:0]       bus_phase_i,
  output logic [7:0]       bus_data_o,
  output logic             bus_data_en_o,
  output logic             bus_ack_o,
  output logic             bus_atn_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic [CNT_W-1:0] left_o
);

  localparam int SYNC_W = 6;

  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] sync_bus;
  logic              req_s;
  logic              bsy_s;
  logic              sel_s;
  logic [2:0]        phase_s;
  logic              bus_free_s;
  logic              tmr_clr;
  logic              tmr_run;
  logic              tmo;
  atx_err_e          err_e;

  assign raw_bus = {bus_phase_i, bus_sel_i, bus_bsy_i, bus_req_i};

  atx_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_bus),
    .sync_o  (sync_bus)
  );

  assign req_s      = sync_bus[0];
  assign bsy_s      = sync_bus[1];
  assign sel_s      = sync_bus[2];
  assign phase_s    = sync_bus[5:3];
  assign bus_free_s = ~bsy_s & ~sel_s;

  atx_timer #(.TO_CYC(TO_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .expired_o (tmo)
  );

  atx_ctrl #(
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .count_i      (count_i),
    .exp_phase_i  (exp_phase_i),
    .atn_raise_i  (atn_raise_i),
    .in_data_i    (in_data_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .req_s_i      (req_s),
    .bus_free_s_i (bus_free_s),
    .phase_s_i    (phase_s),
    .tmo_i        (tmo),
    .tmr_clr_o    (tmr_clr),
    .tmr_run_o    (tmr_run),
    .data_o       (bus_data_o),
    .data_en_o    (bus_data_en_o),
    .ack_o        (bus_ack_o),
    .atn_o        (bus_atn_o),
    .done_o       (done_o),
    .err_o        (err_e),
    .left_o       (left_o)
  );

  assign err_o = err_e;

endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             in_valid,
  input logic [7:0]       data,
  input logic             data_en,
  input logic             ack,
  input logic             atn,
  input logic             done,
  input logic [1:0]       err,
  input logic [CNT_W-1:0] left
);

  logic       take;
  logic       pend_q;
  logic       ack_q;
  logic       prev_en_q;
  logic [7:0] prev_d_q;
  logic [7:0] hold_q;

  assign take = in_ready & in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      ack_q     <= 1'b0;
      prev_en_q <= 1'b0;
      prev_d_q  <= '0;
      hold_q    <= '0;
    end else begin
      ack_q     <= ack;
      prev_en_q <= data_en;
      prev_d_q  <= data;
      if (take) begin
        pend_q <= 1'b1;
      end else if (ack_q && !ack) begin
        pend_q <= 1'b0;
      end
      if (data_en && prev_en_q && (data == prev_d_q)) begin
        if (hold_q != 8'hFF) begin
          hold_q <= hold_q + 1'b1;
        end
      end else begin
        hold_q <= '0;
      end
    end
  end

  AST_ONE_BYTE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !pend_q) else $error("one byte per cycle violated"); // R1
  AST_ATN_CLEAR_AT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_en) |-> !atn) else $error("ATN high at drive"); // R4
  AST_ACK_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> data_en) else $error("ACK without data"); // R5
  AST_DATA_HELD_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(ack)) |-> $stable(data)) else $error("data moved under ACK"); // R5
  AST_SETTLE_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> (32'(hold_q) >= SETTLE_CYC - 1)) else $error("settle too short"); // R5
  AST_COUNT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack) && !done) |-> (left == CNT_W'($past(left) - 1'b1))) else $error("count step"); // R6
  AST_CLEAN_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 2'd0) |-> (left == '0)) else $error("clean end with bytes left"); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_DONE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ack && !data_en)) else $error("bus held at done"); // R8

endmodule

bind async_tx_initiator atx_checker #(
  .CNT_W      (CNT_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_atx_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready_o),
  .in_valid (in_valid_i),
  .data     (bus_data_o),
  .data_en  (bus_data_en_o),
  .ack      (bus_ack_o),
  .atn      (bus_atn_o),
  .done     (done_o),
  .err      (err_o),
  .left     (left_o)
);

// File: tb/async_tx_initiator_tb_top.sv
`timescale 1ns/1ps
module async_tx_initiator_tb_top;

  localparam int CNT_W  = 8;
  localparam int SETTLE = 3;
  localparam int TO     = 40;
  localparam logic [2:0] EXP_PH = 3'b000;
  localparam logic [2:0] BAD_PH = 3'b011;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [CNT_W-1:0] count_i;
  logic             atn_raise_i;
  logic             src_en;
  logic             bus_req_i, bus_bsy_i, bus_sel_i;
  logic [2:0]       bus_phase_i;
  logic [7:0]       in_data_i;
  logic             in_ready_o, bus_data_en_o, bus_ack_o, bus_atn_o, done_o;
  logic [7:0]       bus_data_o;
  logic [1:0]       err_o;
  logic [CNT_W-1:0] left_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int sidx = 0;
  int took = 0;
  int done_cnt = 0;
  int done_long = 0;
  int hold = 0;
  int last_err = 0;
  int last_left = 0;
  int done_cyc = 0;
  logic [7:0] last_taken;
  bit pend = 0;
  bit last_en = 0;
  bit last_ack = 0;
  bit last_done = 0;

  function automatic logic [7:0] src_byte(int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  assign in_data_i = src_byte(sidx);

  async_tx_initiator #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE), .TO_CYC(TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .exp_phase_i(EXP_PH), .atn_raise_i(atn_raise_i),
    .in_data_i(in_data_i), .in_valid_i(src_en), .in_ready_o(in_ready_o),
    .bus_req_i(bus_req_i), .bus_bsy_i(bus_bsy_i), .bus_sel_i(bus_sel_i),
    .bus_phase_i(bus_phase_i), .bus_data_o(bus_data_o),
    .bus_data_en_o(bus_data_en_o), .bus_ack_o(bus_ack_o),
    .bus_atn_o(bus_atn_o), .done_o(done_o), .err_o(err_o), .left_o(left_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // port monitor: stream source, done pulses, settle time, ATN at drive
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) sidx++;
      pend = in_ready_o && src_en;
      if (pend) begin
        took++;
        last_taken = src_byte(sidx);
      end
      if (done_o) begin
        done_cnt++;
        last_err = int'(err_o);
        last_left = int'(left_o);
        done_cyc = cyc;
        if (last_done) done_long++;
      end
      if (bus_data_en_o && last_en && bus_data_o == last_taken) hold++;
      else hold = 0;
      if (bus_data_en_o && !last_en)
        chk(!bus_atn_o, "R4", "atn at drive", int'(bus_atn_o), 0);
      if (bus_ack_o && !last_ack) begin
        chk(hold >= SETTLE, "R5", "settle cycles", hold, SETTLE);
        chk(bus_data_o == last_taken, "R5", "byte on bus", int'(bus_data_o), int'(last_taken));
      end
      last_en = bus_data_en_o;
      last_ack = bus_ack_o;
      last_done = done_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic pulse_start(input int n);
    @(negedge clk);
    count_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_ack(input bit lvl);
    int n = 0;
    while (bus_ack_o !== lvl && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic serve_one();
    @(negedge clk);
    bus_phase_i = EXP_PH;
    bus_req_i = 1'b1;
    wait_ack(1'b1);
    @(negedge clk);
    bus_req_i = 1'b0;
    wait_ack(1'b0);
  endtask

  task automatic wait_done(input int prev);
    int n = 0;
    while (done_cnt == prev && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!bus_ack_o && !bus_atn_o && !bus_data_en_o && !in_ready_o && !done_o,
        "R12", "reset outputs", int'({bus_ack_o, bus_atn_o, bus_data_en_o, in_ready_o, done_o}), 0);
  endtask

  task automatic t_normal();
    int d0 = done_cnt;
    int t0 = took;
    pulse_start(4);
    repeat (10) @(negedge clk);
    chk(!in_ready_o && !bus_data_en_o, "R2", "idle before REQ",
        int'({in_ready_o, bus_data_en_o}), 0);
    chk(took == t0, "R2", "no byte before REQ", took - t0, 0);
    for (int i = 0; i < 4; i++) begin
      serve_one();
      chk(took - t0 == i + 1, "R1", "bytes per REQ", took - t0, i + 1);
      chk(int'(left_o) == 3 - i || done_cnt != d0, "R6", "left step", int'(left_o), 3 - i);
    end
    wait_done(d0);
    chk(done_cnt == d0 + 1, "R10", "one done", done_cnt - d0, 1);
    chk(last_err == 0 && last_left == 0, "R7", "clean end err/left",
        last_err * 256 + last_left, 0);
  endtask

  task automatic t_atn();
    int d0 = done_cnt;
    @(negedge clk);
    atn_raise_i = 1'b1;
    @(negedge clk);
    atn_raise_i = 1'b0;
    @(negedge clk);
    chk(bus_atn_o, "R4", "atn raised idle", int'(bus_atn_o), 1);
    pulse_start(1);
    repeat (3) @(negedge clk);
    chk(bus_atn_o, "R4", "atn held until REQ", int'(bus_atn_o), 1);
    serve_one();
    wait_done(d0);
    chk(!bus_atn_o && last_err == 0, "R4", "atn released", int'(bus_atn_o), 0);
  endtask

  task automatic t_phase();
    int d0 = done_cnt;
    int t0;
    pulse_start(3);
    serve_one();
    t0 = took;
    @(negedge clk);
    bus_phase_i = BAD_PH;
    bus_req_i = 1'b1;
    wait_done(d0);
    bus_req_i = 1'b0;
    bus_phase_i = EXP_PH;
    chk(last_err == 1, "R3", "phase error code", last_err, 1);
    chk(last_left == 2, "R3", "phase left", last_left, 2);
    chk(took == t0 && !bus_data_en_o, "R3", "no byte on mismatch", took - t0, 0);
  endtask

  task automatic t_tmo_req();
    int d0 = done_cnt;
    int c0 = cyc;
    pulse_start(2);
    wait_done(d0);
    chk(last_err == 2 && last_left == 2, "R8", "first-wait timeout",
        last_err * 256 + last_left, 2 * 256 + 2);
    chk(done_cyc - c0 >= TO, "R8", "timeout not early", done_cyc - c0, TO);
  endtask

  task automatic t_tmo_nreq();
    int d0 = done_cnt;
    pulse_start(2);
    @(negedge clk);
    bus_req_i = 1'b1;
    wait_ack(1'b1);
    chk(bus_ack_o, "R5", "ack reached", int'(bus_ack_o), 1);
    wait_done(d0);
    chk(last_err == 2 && last_left == 2, "R8", "second-wait timeout",
        last_err * 256 + last_left, 2 * 256 + 2);
    chk(!bus_ack_o, "R8", "ack released on timeout", int'(bus_ack_o), 0);
    bus_req_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busfree();
    int d0 = done_cnt;
    pulse_start(3);
    serve_one();
    @(negedge clk);
    bus_bsy_i = 1'b0;
    bus_sel_i = 1'b0;
    wait_done(d0);
    chk(last_err == 3 && last_left == 2, "R9", "bus free",
        last_err * 256 + last_left, 3 * 256 + 2);
    bus_bsy_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_zero();
    int d0 = done_cnt;
    int t0 = took;
    pulse_start(0);
    wait_done(d0);
    chk(done_cnt == d0 + 1 && last_err == 0 && last_left == 0, "R11", "zero count",
        last_err * 256 + last_left, 0);
    chk(took == t0, "R11", "no byte on zero count", took - t0, 0);
  endtask

  task automatic t_ignore_start();
    int d0 = done_cnt;
    int t0 = took;
    pulse_start(2);
    serve_one();
    pulse_start(5);
    serve_one();
    wait_done(d0);
    repeat (20) @(negedge clk);
    chk(done_cnt == d0 + 1 && last_left == 0, "R10", "start ignored while busy",
        done_cnt - d0, 1);
    chk(took - t0 == 2 && !in_ready_o, "R10", "no extra bytes", took - t0, 2);
    chk(done_long == 0, "R10", "done pulse width", done_long, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    count_i = '0;
    atn_raise_i = 1'b0;
    src_en = 1'b1;
    bus_req_i = 1'b0;
    bus_bsy_i = 1'b1;
    bus_sel_i = 1'b0;
    bus_phase_i = EXP_PH;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_normal();
    t_atn();
    t_phase();
    t_tmo_req();
    t_tmo_nreq();
    t_busfree();
    t_zero();
    t_ignore_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule